// File: doc/BRIEF.md
# Streaming 2x2 Max Pooling Unit

This block shrinks a feature map that arrives as a pixel stream in raster order. It takes the largest value from each 2x2 group of pixels that does not overlap its neighbours, so the image it sends out is half as wide and half as high as the image it receives. Pixels come in one per transfer on a valid/ready stream. Pooled pixels leave one per transfer on a second valid/ready stream, also in raster order.

The unit never holds a whole frame. For each lane it keeps one register for the left pixel of a horizontal pair, and one row of half-width storage for the pair maxima of the even row above. On an odd row, the unit emits a result at each odd column: the larger of the stored upper pair and the lower pair that has just arrived. Every transfer carries several channels side by side, and the unit pools each channel on its own. Values are signed fixed point. A start-of-frame flag sent with a pixel returns the position counters to the top-left corner, and this can happen in the middle of a frame.

Top module: `maxpool2x2_stream`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `out_valid` is low and `in_ready` is high.
- R2: Each output lane is the largest of the four input values at rows 2i and 2i+1 and columns 2j and 2j+1. Groups do not overlap, and the step between groups is 2 in both directions.
- R3: A frame of IMG_W x IMG_H pixels gives exactly floor(IMG_W/2) x floor(IMG_H/2) outputs, in raster order. When the last pixel of a frame is accepted, the position returns to row 0, column 0. A next frame sent without the start flag is therefore pooled in the same way.
- R4: When IMG_W is odd, the last column of each row takes part in no output. When IMG_H is odd, the last row takes part in no output.
- R5: Comparison is in signed two's complement. 0x8000 is the smallest 16-bit value, 0x7FFF is the largest, and 0xFFFF (-1) is smaller than 0x0001.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` holds its value.
- R7: `in_ready` is low exactly when `out_valid` is high and `out_ready` is low.
- R8: An accepted pixel with `in_sof` high is treated as row 0, column 0, whatever the counters held. A partial frame that is cut off this way emits only the groups that were complete. No output follows in the next cycle.
- R9: The output for a group appears with `out_valid` high in the cycle right after the clock edge that accepts the group's bottom-right pixel.
- R10: Lane k uses bits [k*DATA_W +: DATA_W] of both `in_data` and `out_data`. Each lane is pooled on its own.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input pixel is valid |
| in_ready | output | 1 | Unit can accept an input pixel |
| in_sof | input | 1 | Marks the pixel as the first pixel of a frame |
| in_data | input | CHANNELS*DATA_W | Packed input lanes, one signed value per channel |
| out_valid | output | 1 | Pooled pixel is valid |
| out_ready | input | 1 | Downstream can take the pooled pixel |
| out_data | output | CHANNELS*DATA_W | Packed pooled lanes |

## Verification
The bench builds the unit with a 7x5 image, two channels and 16-bit lanes. The odd width and odd height exercise the dropped last column and dropped last row. Two lanes are enough to show that channels are pooled apart and packed in the stated positions. Because the row buffer holds only three entries, frame wrap, restarts in mid-frame and random back-pressure all occur within a few hundred cycles. The bench also uses stimulus with the extreme signed values to test the signed comparison.

// File: rtl/maxpool_pkg.sv
package maxpool_pkg;

    // Position flags of the pixel being presented, as seen after a
    // possible start-of-frame override.
    typedef struct packed {
        logic col_odd;
        logic row_odd;
        logic col_ok;   // column belongs to a full horizontal pair
        logic row_ok;   // row belongs to a full vertical pair
    } pool_pos_t;

endpackage

// File: rtl/mp_raster_pos.sv
module mp_raster_pos
    import maxpool_pkg::*;
#(
    parameter int IMG_W = 28,
    parameter int IMG_H = 28,
    parameter int COL_W = 5,
    parameter int ROW_W = 5,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             sof,
    output pool_pos_t        pos,
    output logic [IDX_W-1:0] pair_idx
);

    localparam bit W_ODD = (IMG_W % 2) == 1;
    localparam bit H_ODD = (IMG_H % 2) == 1;

    typedef struct packed {
        logic [COL_W-1:0] col;
        logic [ROW_W-1:0] row;
    } pos_state_t;

    pos_state_t st_q, st_d;
    logic [COL_W-1:0] eff_col;
    logic [ROW_W-1:0] eff_row;
    logic [COL_W-1:0] half_col;
    logic             last_col;
    logic             last_row;

    always_comb begin
        eff_col  = sof ? '0 : st_q.col;
        eff_row  = sof ? '0 : st_q.row;
        last_col = (eff_col == COL_W'(IMG_W - 1));
        last_row = (eff_row == ROW_W'(IMG_H - 1));
        half_col = eff_col >> 1;

        pos.col_odd = eff_col[0];
        pos.row_odd = eff_row[0];
        pos.col_ok  = !(W_ODD && last_col);
        pos.row_ok  = !(H_ODD && last_row);
        pair_idx    = half_col[IDX_W-1:0];

        st_d = st_q;
        if (step) begin
            if (last_col) begin
                st_d.col = '0;
                st_d.row = last_row ? '0 : eff_row + ROW_W'(1);
            end else begin
                st_d.col = eff_col + COL_W'(1);
                st_d.row = eff_row;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/mp_lane.sv
module mp_lane
    import maxpool_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int HALF_W = 14,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  pool_pos_t         pos,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] pix,
    output logic [DATA_W-1:0] pooled
);

    typedef struct packed {
        logic [DATA_W-1:0]             hold;
        logic [HALF_W-1:0][DATA_W-1:0] upper;
    } lane_state_t;

    lane_state_t st_q, st_d;
    logic [DATA_W-1:0] pair_max;
    logic [DATA_W-1:0] upper_sel;

    function automatic logic [DATA_W-1:0] smax(input logic [DATA_W-1:0] a,
                                               input logic [DATA_W-1:0] b);
        return ($signed(a) > $signed(b)) ? a : b;
    endfunction

    always_comb begin
        upper_sel = (int'(idx) < HALF_W) ? st_q.upper[idx] : '0;
        pair_max  = smax(st_q.hold, pix);
        pooled    = smax(upper_sel, pair_max);

        st_d = st_q;
        if (take && pos.col_ok) begin
            if (!pos.col_odd) begin
                st_d.hold = pix;
            end else if (!pos.row_odd && (int'(idx) < HALF_W)) begin
                st_d.upper[idx] = pair_max;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/mp_out_stage.sv
module mp_out_stage #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_data,
    input  logic             out_ready,
    output logic             out_valid,
    output logic [WIDTH-1:0] out_data,
    output logic             free
);

    typedef struct packed {
        logic             valid;
        logic [WIDTH-1:0] data;
    } stage_t;

    stage_t st_q, st_d;

    always_comb begin
        free = !st_q.valid || out_ready;
        st_d = st_q;
        if (load) begin
            st_d.valid = 1'b1;
            st_d.data  = load_data;
        end else if (out_ready) begin
            st_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign out_data  = st_q.data;

endmodule

// File: rtl/maxpool2x2_stream.sv
module maxpool2x2_stream
    import maxpool_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int CHANNELS = 1,
    parameter int IMG_W    = 28,
    parameter int IMG_H    = 28
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid,
    output logic                         in_ready,
    input  logic                         in_sof,
    input  logic [CHANNELS*DATA_W-1:0]   in_data,
    output logic                         out_valid,
    input  logic                         out_ready,
    output logic [CHANNELS*DATA_W-1:0]   out_data
);

    localparam int BUS_W  = CHANNELS * DATA_W;
    localparam int HALF_W = IMG_W / 2;
    localparam int COL_W  = (IMG_W > 2) ? $clog2(IMG_W) : 1;
    localparam int ROW_W  = (IMG_H > 2) ? $clog2(IMG_H) : 1;
    localparam int IDX_W  = (HALF_W > 1) ? $clog2(HALF_W) : 1;

    pool_pos_t        pos;
    logic [IDX_W-1:0] pair_idx;
    logic             take;
    logic             emit;
    logic             stage_free;
    logic [BUS_W-1:0] pooled_bus;

    assign in_ready = stage_free;
    assign take     = in_valid && stage_free;
    assign emit     = take && pos.col_odd && pos.row_odd && pos.col_ok && pos.row_ok;

    mp_raster_pos #(
        .IMG_W (IMG_W),
        .IMG_H (IMG_H),
        .COL_W (COL_W),
        .ROW_W (ROW_W),
        .IDX_W (IDX_W)
    ) pos_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (take),
        .sof      (in_sof),
        .pos      (pos),
        .pair_idx (pair_idx)
    );

    for (genvar g = 0; g < CHANNELS; g++) begin : g_lane
        mp_lane #(
            .DATA_W (DATA_W),
            .HALF_W (HALF_W),
            .IDX_W  (IDX_W)
        ) lane_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .take   (take),
            .pos    (pos),
            .idx    (pair_idx),
            .pix    (in_data[g*DATA_W +: DATA_W]),
            .pooled (pooled_bus[g*DATA_W +: DATA_W])
        );
    end

    mp_out_stage #(
        .WIDTH (BUS_W)
    ) out_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (emit),
        .load_data (pooled_bus),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .free      (stage_free)
    );

endmodule

// File: rtl/mp_pool_checker.sv
module mp_pool_checker #(
    parameter int BITS = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic            in_ready,
    input logic            in_sof,
    input logic            out_valid,
    input logic            out_ready,
    input logic [BITS-1:0] out_data
);

    AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> !out_valid); // R1

    AST_STALL_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> $stable(out_data)); // R6

    AST_STALL_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid); // R6

    AST_NO_TAKE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready); // R7

    AST_SOF_NO_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && in_sof |=> !out_valid); // R8

    AST_OUT_FROM_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(in_valid && in_ready)); // R9

endmodule

bind maxpool2x2_stream mp_pool_checker #(
    .BITS (CHANNELS * DATA_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_sof    (in_sof),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
);

// File: tb/maxpool2x2_stream_tb_top.sv
module maxpool2x2_stream_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int W  = 7;
    localparam int H  = 5;
    localparam int CH = 2;
    localparam int DW = 16;
    localparam int BW = CH * DW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic          in_sof = 1'b0;
    logic [BW-1:0] in_data = '0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [BW-1:0] out_data;

    int    n_tests = 0;
    int    n_fail  = 0;
    int    n_pushed = 0;
    int    n_popped = 0;
    bit    mon_on = 1'b0;
    bit    bp_on  = 1'b0;
    bit    finished = 1'b0;
    string tag = "R2";
    logic [BW-1:0] exp_q[$];
    logic [15:0]   lfsr = 16'hACE1;

    always #(CLK_PERIOD/2) clk = ~clk;

    maxpool2x2_stream #(
        .DATA_W   (DW),
        .CHANNELS (CH),
        .IMG_W    (W),
        .IMG_H    (H)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_sof    (in_sof),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data)
    );

    function automatic logic [DW-1:0] pix_val(int pat, int seed, int ch, int r, int c);
        logic [31:0] h;
        int k;
        case (pat)
            0: return DW'(r * W + c + ch * 50 + seed);
            1: begin
                k = (r * 3 + c * 5 + ch + seed) % 5;
                case (k)
                    0: return 16'h8000;
                    1: return 16'h7FFF;
                    2: return 16'hFFFF;
                    3: return 16'h0001;
                    default: return 16'h0000;
                endcase
            end
            default: begin
                h = 32'(r * 131 + c * 17 + ch * 7 + seed * 1009) * 32'd2654435761;
                return h[23:8];
            end
        endcase
    endfunction

    function automatic logic [DW-1:0] smax(logic [DW-1:0] a, logic [DW-1:0] b);
        return ($signed(a) > $signed(b)) ? a : b;
    endfunction

    task automatic check(bit ok, string req, logic [BW-1:0] act, logic [BW-1:0] expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    // Driver side: push expected pooled words for the complete groups.
    task automatic push_expected(int pat, int seed, int rows_sent);
        for (int gr = 0; gr < H / 2; gr++) begin
            if (2 * gr + 1 < rows_sent) begin
                for (int gc = 0; gc < W / 2; gc++) begin
                    logic [BW-1:0] w;
                    for (int ch = 0; ch < CH; ch++) begin
                        logic [DW-1:0] m;
                        m = pix_val(pat, seed, ch, 2 * gr, 2 * gc);
                        m = smax(m, pix_val(pat, seed, ch, 2 * gr, 2 * gc + 1));
                        m = smax(m, pix_val(pat, seed, ch, 2 * gr + 1, 2 * gc));
                        m = smax(m, pix_val(pat, seed, ch, 2 * gr + 1, 2 * gc + 1));
                        w[ch * DW +: DW] = m;
                    end
                    exp_q.push_back(w);
                    n_pushed++;
                end
            end
        end
    endtask

    task automatic drive_beat(logic [BW-1:0] d, logic sof);
        bit done = 1'b0;
        while (!done) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = d;
            in_sof   = sof;
            #1;
            if (in_ready) done = 1'b1;
        end
        @(posedge clk);
    endtask

    task automatic send_frame(int pat, int seed, int rows, bit with_sof, bit lat);
        push_expected(pat, seed, rows);
        for (int r = 0; r < rows; r++) begin
            for (int c = 0; c < W; c++) begin
                logic [BW-1:0] d;
                for (int ch = 0; ch < CH; ch++) d[ch * DW +: DW] = pix_val(pat, seed, ch, r, c);
                drive_beat(d, with_sof && r == 0 && c == 0);
                if (lat) begin
                    bit expv;
                    @(negedge clk);
                    in_valid = 1'b0;
                    #2;
                    expv = (r % 2 == 1) && (c % 2 == 1) && (r < H - H % 2) && (c < W - W % 2);
                    check(out_valid == expv, "R9 R4 latency", BW'(out_valid), BW'(expv));
                end
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_sof   = 1'b0;
    endtask

    // Monitor: pops and compares as results are handed over.
    always @(negedge clk) begin
        if (mon_on) begin
            logic          v;
            logic [BW-1:0] d;
            static bit            prev_stall = 1'b0;
            static logic [BW-1:0] prev_d = '0;
            v = out_valid;
            d = out_data;
            if (prev_stall) check(v && d == prev_d, "R6 hold under stall", d, prev_d);
            out_ready = bp_on ? lfsr[0] : 1'b1;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (v && out_ready) begin
                n_popped++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3 unexpected output", d, '0);
                end else begin
                    logic [BW-1:0] e;
                    e = exp_q.pop_front();
                    check(d == e, tag, d, e);
                end
            end
            prev_stall = v && !out_ready;
            prev_d     = d;
            #1;
            if (v && !out_ready) check(!in_ready, "R7 ready while stalled", BW'(in_ready), '0);
            else check(in_ready, "R7 ready while free", BW'(in_ready), BW'(1));
        end
    end

    task automatic drain();
        int guard = 0;
        while ((exp_q.size() != 0 || out_valid) && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!out_valid, "R1 out_valid in reset", BW'(out_valid), '0);
        check(in_ready, "R1 in_ready in reset", BW'(in_ready), BW'(1));
        rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid && in_ready, "R1 after reset", BW'({out_valid, in_ready}), BW'(1));
        mon_on = 1'b1;

        tag = "R2 R3 R4 ramp";
        send_frame(0, 0, H, 1'b1, 1'b0);
        drain();

        tag = "R5 R10 R6 signed extremes";
        bp_on = 1'b1;
        send_frame(1, 0, H, 1'b1, 1'b0);
        send_frame(1, 2, H, 1'b1, 1'b0);
        drain();

        tag = "R3 wrap without start flag";
        send_frame(2, 1, H, 1'b0, 1'b0);
        drain();

        tag = "R8 restart";
        send_frame(2, 3, 3, 1'b1, 1'b0);
        send_frame(0, 9, H, 1'b1, 1'b0);
        drain();

        tag = "R9 R2 isolated beats";
        bp_on = 1'b0;
        send_frame(2, 5, H, 1'b1, 1'b1);
        drain();

        check(exp_q.size() == 0, "R3 all expected outputs seen", BW'(exp_q.size()), '0);
        check(n_popped == n_pushed, "R3 output count", BW'(n_popped), BW'(n_pushed));
        finish_run();
    end

endmodule